// File: doc/BRIEF.md
# Fine-Grain Round-Robin Thread Issue Selector

This block chooses, every clock cycle, which hardware thread of an in-order fine-grain multithreaded pipeline gets the fetch slot. It holds a program counter and a ready flag for each of two to four threads. It grants the slot in round-robin order among the threads that are ready and sends the granted thread's PC to the fetch stage. A thread can be granted on consecutive cycles, and switching from one thread to another costs no cycle.

When a thread misses in the instruction cache or the data cache, the miss port names the thread and the PC to restart from. The block then does four things. It stops granting that thread in the same cycle. It marks the thread stalled. It reloads the thread's PC with the restart address. It raises a one-cycle squash command for that thread. An instruction-cache miss squashes only the lost fetch. A data-cache miss squashes the thread's younger in-flight work.

The other threads keep issuing. A refill-done pulse returns the stalled thread to the ready set; with the usual miss penalty it arrives about 20 cycles after the miss. When no thread is eligible, the block emits a bubble and keeps its rotation pointer.

Each thread runs a two-state machine: THR_READY and THR_STALLED. A miss takes THR_READY to THR_STALLED. A refill with no miss in the same cycle takes THR_STALLED back to THR_READY. A miss in THR_STALLED keeps the thread in THR_STALLED. The issue stage has two states: SEL_ISSUE when a thread was granted at the last edge and SEL_BUBBLE when none was. It enters whichever matches the presence of an eligible thread at each edge.

Top module: `mt_issue_sel`

## Requirements
- R1: While reset is asserted, fetch_valid and both squash masks are 0 and ready_mask is all ones. At the first edge after reset, thread 0 is granted with its boot PC, which is BOOT_PC + thread_index * BOOT_STRIDE.
- R2: At each edge the block grants the first eligible thread, searching upward from the rotation pointer and wrapping from the last thread back to 0. A thread is eligible when it is ready and has no miss in that cycle. After a grant the pointer moves to the thread after the granted one.
- R3: fetch_pc is the granted thread's PC, and every grant adds INSN_BYTES to that thread's PC. Grant outputs are registered: they appear one edge after the inputs they were chosen from.
- R4: An instruction-cache miss for thread t masks t from the grant at that edge. After that edge ready_mask bit t is 0 and squash_fetch_mask is one-hot at bit t for one cycle. The next grant of t fetches the miss PC.
- R5: A data-cache miss for thread t masks t from the grant at that edge. After that edge ready_mask bit t is 0 and squash_pipe_mask is one-hot at bit t for one cycle. The next grant of t fetches the given restart PC.
- R6: Stalled threads are skipped, and the remaining ready threads are granted on every cycle with no bubble.
- R7: When no thread is eligible, fetch_valid is 0, fetch_tid and fetch_pc are 0, and the rotation pointer is held.
- R8: refill_done bit t returns a stalled thread t to ready at the next edge. A refill_done bit for a thread that is already ready leaves ready_mask and the grant sequence unchanged.
- R9: When a refill and a new miss hit the same thread in the same cycle, the miss wins and the thread stays stalled.
- R10: When both miss ports name the same thread in the same cycle, the thread's PC is reloaded from the data-cache restart PC, and both squash masks carry its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imiss_vld | input | 1 | Instruction-cache miss this cycle |
| imiss_tid | input | TID_W | Thread that missed in the instruction cache |
| imiss_pc | input | PC_W | PC of the fetch that missed |
| dmiss_vld | input | 1 | Data-cache miss this cycle |
| dmiss_tid | input | TID_W | Thread that missed in the data cache |
| dmiss_pc | input | PC_W | PC of the missing instruction, to fetch again |
| refill_done | input | NUM_THREADS | Per-thread refill complete pulse |
| fetch_valid | output | 1 | A thread is granted the fetch slot |
| fetch_tid | output | TID_W | Granted thread |
| fetch_pc | output | PC_W | PC to fetch for the granted thread |
| squash_fetch_mask | output | NUM_THREADS | Remove the missed fetch of these threads |
| squash_pipe_mask | output | NUM_THREADS | Remove younger in-flight work of these threads |
| ready_mask | output | NUM_THREADS | Ready flag of each thread |

## Verification
A stuck per-thread state machine shows up one edge after the event. A thread that stays THR_READY after a miss is granted again. A thread that stays THR_STALLED after a refill is never granted. Either case also shows directly on ready_mask. A corrupted PC register shows on the next fetch_pc of that thread, which may be several cycles later. A wrong rotation pointer shows within one grant as an out-of-order fetch_tid. The bench compares every cycle's outputs against an independent cycle model, so each of these is reported at the first cycle where it becomes visible.

// File: rtl/mt_sel_pkg.sv
`timescale 1ns/1ps
package mt_sel_pkg;

    // Per-thread readiness state
    typedef enum logic {
        THR_READY   = 1'b0,
        THR_STALLED = 1'b1
    } thr_state_e;

    // Issue-slot state: did the last edge grant a thread
    typedef enum logic {
        SEL_BUBBLE = 1'b0,
        SEL_ISSUE  = 1'b1
    } sel_state_e;

endpackage

// File: rtl/mt_thread_ctx.sv
`timescale 1ns/1ps
module mt_thread_ctx
    import mt_sel_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] BOOT_PC    = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imiss,
    input  logic [PC_W-1:0] imiss_pc,
    input  logic            dmiss,
    input  logic [PC_W-1:0] dmiss_pc,
    input  logic            refill,
    input  logic            grant,
    output logic            ready,
    output logic [PC_W-1:0] pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    thr_state_e      st_q;
    thr_state_e      st_d;
    logic            any_miss;
    logic [PC_W-1:0] pc_q;

    assign any_miss = imiss | dmiss;

    // Transitions: miss stalls; refill without a concurrent miss resumes
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            THR_READY:   if (any_miss) st_d = THR_STALLED;
            THR_STALLED: if (refill && !any_miss) st_d = THR_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= THR_READY;
        else        st_q <= st_d;
    end

    // PC: data-side restart beats fetch-side restart beats sequential step
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= BOOT_PC;
        else if (dmiss) pc_q <= dmiss_pc;
        else if (imiss) pc_q <= imiss_pc;
        else if (grant) pc_q <= pc_q + STEP;
    end

    assign ready = (st_q == THR_READY);
    assign pc    = pc_q;

endmodule

// File: rtl/mt_rr_pick.sv
`timescale 1ns/1ps
module mt_rr_pick #(
    parameter int NT    = 4,
    parameter int TID_W = 2
) (
    input  logic [NT-1:0]    eligible,
    input  logic [TID_W-1:0] ptr,
    output logic             any,
    output logic [TID_W-1:0] pick
);

    // Search upward from the pointer with wrap; first eligible wins
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 0; k < NT; k++) begin
            logic [TID_W-1:0] idx;
            idx = TID_W'((int'(ptr) + k) % NT);
            if (!any && eligible[idx]) begin
                any  = 1'b1;
                pick = idx;
            end
        end
    end

endmodule

// File: rtl/mt_issue_sel.sv
`timescale 1ns/1ps
module mt_issue_sel
    import mt_sel_pkg::*;
#(
    parameter int              NUM_THREADS = 4,
    parameter int              PC_W        = 32,
    parameter int              INSN_BYTES  = 4,
    parameter logic [PC_W-1:0] BOOT_PC     = 32'h0000_1000,
    parameter logic [PC_W-1:0] BOOT_STRIDE = 32'h0001_0000,
    localparam int             TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   imiss_vld,
    input  logic [TID_W-1:0]       imiss_tid,
    input  logic [PC_W-1:0]        imiss_pc,
    input  logic                   dmiss_vld,
    input  logic [TID_W-1:0]       dmiss_tid,
    input  logic [PC_W-1:0]        dmiss_pc,
    input  logic [NUM_THREADS-1:0] refill_done,
    output logic                   fetch_valid,
    output logic [TID_W-1:0]       fetch_tid,
    output logic [PC_W-1:0]        fetch_pc,
    output logic [NUM_THREADS-1:0] squash_fetch_mask,
    output logic [NUM_THREADS-1:0] squash_pipe_mask,
    output logic [NUM_THREADS-1:0] ready_mask
);

    localparam int               NT       = NUM_THREADS;
    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NT - 1);
    localparam logic [NT-1:0]    ONE_HOT0 = NT'(1);

    if (NUM_THREADS < 2 || NUM_THREADS > 4) begin : g_bad_count
        $error("NUM_THREADS must lie in 2..4");
    end

    logic [NT-1:0]    imiss_vec;
    logic [NT-1:0]    dmiss_vec;
    logic [NT-1:0]    miss_vec;
    logic [NT-1:0]    ready_vec;
    logic [NT-1:0]    elig_vec;
    logic [NT-1:0]    grant_vec;
    logic [PC_W-1:0]  pc_arr [NT];
    logic             pick_any;
    logic [TID_W-1:0] pick_tid;
    logic [TID_W-1:0] ptr_q;

    sel_state_e       sel_q;
    sel_state_e       sel_d;
    logic [TID_W-1:0] tid_q;
    logic [PC_W-1:0]  pc_q;
    logic [NT-1:0]    sqf_q;
    logic [NT-1:0]    sqp_q;

    // Decode the miss ports into per-thread vectors
    assign imiss_vec = imiss_vld ? (ONE_HOT0 << imiss_tid) : '0;
    assign dmiss_vec = dmiss_vld ? (ONE_HOT0 << dmiss_tid) : '0;
    assign miss_vec  = imiss_vec | dmiss_vec;

    // A thread that misses this cycle is removed from the grant immediately
    assign elig_vec  = ready_vec & ~miss_vec;
    assign grant_vec = pick_any ? (ONE_HOT0 << pick_tid) : '0;

    for (genvar g = 0; g < NT; g++) begin : g_thr
        localparam logic [PC_W-1:0] THR_BOOT = BOOT_PC + BOOT_STRIDE * PC_W'(g);
        mt_thread_ctx #(
            .PC_W       (PC_W),
            .INSN_BYTES (INSN_BYTES),
            .BOOT_PC    (THR_BOOT)
        ) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .imiss    (imiss_vec[g]),
            .imiss_pc (imiss_pc),
            .dmiss    (dmiss_vec[g]),
            .dmiss_pc (dmiss_pc),
            .refill   (refill_done[g]),
            .grant    (grant_vec[g]),
            .ready    (ready_vec[g]),
            .pc       (pc_arr[g])
        );
    end

    mt_rr_pick #(
        .NT    (NT),
        .TID_W (TID_W)
    ) u_pick (
        .eligible (elig_vec),
        .ptr      (ptr_q),
        .any      (pick_any),
        .pick     (pick_tid)
    );

    // Rotation pointer: moves past the granted thread, holds on a bubble
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (pick_any) ptr_q <= (pick_tid == LAST_TID) ? '0 : pick_tid + 1'b1;
    end

    // Issue-slot state
    assign sel_d = pick_any ? SEL_ISSUE : SEL_BUBBLE;

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_BUBBLE;
        else        sel_q <= sel_d;
    end

    // Registered outputs, chosen by the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tid_q <= '0;
            pc_q  <= '0;
            sqf_q <= '0;
            sqp_q <= '0;
        end else begin
            unique case (sel_d)
                SEL_ISSUE: begin
                    tid_q <= pick_tid;
                    pc_q  <= pc_arr[pick_tid];
                end
                SEL_BUBBLE: begin
                    tid_q <= '0;
                    pc_q  <= '0;
                end
            endcase
            sqf_q <= imiss_vec;
            sqp_q <= dmiss_vec;
        end
    end

    assign fetch_valid       = (sel_q == SEL_ISSUE);
    assign fetch_tid         = tid_q;
    assign fetch_pc          = pc_q;
    assign squash_fetch_mask = sqf_q;
    assign squash_pipe_mask  = sqp_q;
    assign ready_mask        = ready_vec;

endmodule

// File: rtl/mt_issue_sel_chk.sv
`timescale 1ns/1ps
module mt_issue_sel_chk #(
    parameter int NT    = 4,
    parameter int TID_W = 2,
    parameter int PC_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             imiss_vld,
    input logic [TID_W-1:0] imiss_tid,
    input logic             dmiss_vld,
    input logic [TID_W-1:0] dmiss_tid,
    input logic [NT-1:0]    refill_done,
    input logic             fetch_valid,
    input logic [TID_W-1:0] fetch_tid,
    input logic [PC_W-1:0]  fetch_pc,
    input logic [NT-1:0]    squash_fetch_mask,
    input logic [NT-1:0]    squash_pipe_mask,
    input logic [NT-1:0]    ready_mask
);

    logic          armed_q;
    logic [NT-1:0] miss_now;
    logic [NT-1:0] elig_now;
    logic [NT-1:0] refill_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign miss_now  = (imiss_vld ? (NT'(1) << imiss_tid) : '0)
                     | (dmiss_vld ? (NT'(1) << dmiss_tid) : '0);
    assign elig_now  = ready_mask & ~miss_now;
    assign refill_ok = refill_done & ~miss_now;

    AST_GRANT_WAS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        fetch_valid |-> (($past(elig_now) & (NT'(1) << fetch_tid)) != '0)); // R6

    AST_BUBBLE_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !fetch_valid |-> ($past(elig_now) == '0)); // R7

    AST_IMISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        imiss_vld |=> (!ready_mask[$past(imiss_tid)] && squash_fetch_mask[$past(imiss_tid)])); // R4

    AST_DMISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        dmiss_vld |=> (!ready_mask[$past(dmiss_tid)] && squash_pipe_mask[$past(dmiss_tid)])); // R5

    AST_REFILL_RESUMES: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (refill_ok != '0) |=> ((ready_mask & $past(refill_ok)) == $past(refill_ok))); // R8

    AST_MISS_BEATS_REFILL: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (imiss_vld && refill_done[imiss_tid]) |=> !ready_mask[$past(imiss_tid)]); // R9

    AST_BUBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !fetch_valid |-> (fetch_pc == '0 && fetch_tid == '0)); // R7

endmodule

bind mt_issue_sel mt_issue_sel_chk #(
    .NT    (NUM_THREADS),
    .TID_W (TID_W),
    .PC_W  (PC_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .imiss_vld         (imiss_vld),
    .imiss_tid         (imiss_tid),
    .dmiss_vld         (dmiss_vld),
    .dmiss_tid         (dmiss_tid),
    .refill_done       (refill_done),
    .fetch_valid       (fetch_valid),
    .fetch_tid         (fetch_tid),
    .fetch_pc          (fetch_pc),
    .squash_fetch_mask (squash_fetch_mask),
    .squash_pipe_mask  (squash_pipe_mask),
    .ready_mask        (ready_mask)
);

// File: tb/mt_issue_sel_bench.sv
`timescale 1ns/1ps
module mt_issue_sel_bench;

    localparam real CLK_HALF = 4.0;   // 125 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imiss_vld = 1'b0;
    logic [1:0]  imiss_tid = '0;
    logic [31:0] imiss_pc = '0;
    logic        dmiss_vld = 1'b0;
    logic [1:0]  dmiss_tid = '0;
    logic [31:0] dmiss_pc = '0;
    logic [3:0]  refill_done = '0;
    logic        fetch_valid;
    logic [1:0]  fetch_tid;
    logic [31:0] fetch_pc;
    logic [3:0]  squash_fetch_mask;
    logic [3:0]  squash_pipe_mask;
    logic [3:0]  ready_mask;

    always #(CLK_HALF) clk = ~clk;

    mt_issue_sel u_mt_issue_sel (
        .clk               (clk),
        .rst_n             (rst_n),
        .imiss_vld         (imiss_vld),
        .imiss_tid         (imiss_tid),
        .imiss_pc          (imiss_pc),
        .dmiss_vld         (dmiss_vld),
        .dmiss_tid         (dmiss_tid),
        .dmiss_pc          (dmiss_pc),
        .refill_done       (refill_done),
        .fetch_valid       (fetch_valid),
        .fetch_tid         (fetch_tid),
        .fetch_pc          (fetch_pc),
        .squash_fetch_mask (squash_fetch_mask),
        .squash_pipe_mask  (squash_pipe_mask),
        .ready_mask        (ready_mask)
    );

    typedef struct {
        logic        fv;
        logic [1:0]  tid;
        logic [31:0] pc;
        logic [3:0]  sqf;
        logic [3:0]  sqp;
        logic [3:0]  rdy;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Reference model state, built from the requirements
    logic [31:0] m_pc [4];
    logic [3:0]  m_rdy;
    int          m_ptr;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, predict the registered result
    task automatic cyc(input bit iv, input int it, input logic [31:0] ip,
                       input bit dv, input int dt, input logic [31:0] dp,
                       input logic [3:0] rf, input string tag);
        exp_t       e;
        logic [3:0] miss;
        logic [3:0] elig;
        int         g;
        imiss_vld   = iv;
        imiss_tid   = it[1:0];
        imiss_pc    = ip;
        dmiss_vld   = dv;
        dmiss_tid   = dt[1:0];
        dmiss_pc    = dp;
        refill_done = rf;
        miss = '0;
        if (iv) miss[it] = 1'b1;
        if (dv) miss[dt] = 1'b1;
        elig = m_rdy & ~miss;
        g = -1;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = (m_ptr + k) % 4;
            if (g < 0 && elig[idx]) g = idx;
        end
        e.fv  = (g >= 0);
        e.tid = (g >= 0) ? g[1:0] : 2'd0;
        e.pc  = (g >= 0) ? m_pc[g] : 32'd0;
        e.sqf = iv ? (4'b1 << it) : 4'b0;
        e.sqp = dv ? (4'b1 << dt) : 4'b0;
        if (g >= 0) begin
            m_pc[g] = m_pc[g] + 32'd4;
            m_ptr   = (g + 1) % 4;
        end
        if (iv) m_pc[it] = ip;
        if (dv) m_pc[dt] = dp;
        m_rdy = (m_rdy | rf) & ~miss;
        e.rdy = m_rdy;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 4'b0, tag);
    endtask

    // Monitor: pop one prediction per edge and compare
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(fetch_valid == e.fv, e.tag, "fetch_valid", 32'(fetch_valid), 32'(e.fv));
                chk(fetch_tid == e.tid, e.tag, "fetch_tid", 32'(fetch_tid), 32'(e.tid));
                chk(fetch_pc == e.pc, e.tag, "fetch_pc", fetch_pc, e.pc);
                chk(squash_fetch_mask == e.sqf, e.tag, "squash_fetch_mask",
                    32'(squash_fetch_mask), 32'(e.sqf));
                chk(squash_pipe_mask == e.sqp, e.tag, "squash_pipe_mask",
                    32'(squash_pipe_mask), 32'(e.sqp));
                chk(ready_mask == e.rdy, e.tag, "ready_mask", 32'(ready_mask), 32'(e.rdy));
            end
        end
    end

    initial begin
        #(2.0 * CLK_HALF * 200000.0);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 4; t++) m_pc[t] = 32'h0000_1000 + 32'h0001_0000 * t;
        m_rdy = 4'hF;
        m_ptr = 0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fetch_valid == 1'b0, "R1", "reset fetch_valid", 32'(fetch_valid), 32'd0);
        chk(ready_mask == 4'hF, "R1", "reset ready_mask", 32'(ready_mask), 32'hF);
        chk(squash_fetch_mask == 4'h0, "R1", "reset squash_fetch_mask",
            32'(squash_fetch_mask), 32'd0);
        chk(squash_pipe_mask == 4'h0, "R1", "reset squash_pipe_mask",
            32'(squash_pipe_mask), 32'd0);
        rst_n = 1'b1;

        cyc(0, 0, 0, 0, 0, 0, 4'b0, "R1");      // first grant: thread 0 boot PC
        idle(5, "R2");                           // rotation with wrap
        idle(4, "R3");                           // PC stepping

        cyc(1, 2, 32'h2000_0000, 0, 0, 0, 4'b0, "R4");
        idle(4, "R6");                           // thread 2 skipped, no bubble

        cyc(0, 0, 0, 1, 0, 32'h3000_0040, 4'b0, "R5");
        idle(3, "R6");

        cyc(1, 2, 32'h2000_0100, 0, 0, 0, 4'b0100, "R9");  // refill and miss collide
        idle(2, "R9");

        idle(20, "R6");                          // refill latency
        cyc(0, 0, 0, 0, 0, 0, 4'b0110, "R8");    // t2 resumes, t1 already ready
        idle(4, "R4");                           // t2 refetches its miss PC
        cyc(0, 0, 0, 0, 0, 0, 4'b0001, "R8");    // t0 resumes
        idle(4, "R5");                           // t0 refetches its restart PC

        cyc(1, 1, 32'h4000_0000, 1, 1, 32'h4000_0800, 4'b0, "R10");
        idle(3, "R10");
        cyc(0, 0, 0, 0, 0, 0, 4'b0010, "R10");
        idle(4, "R10");                          // t1 fetches data-side restart PC

        cyc(1, 1, 32'h5000_0000, 1, 3, 32'h5000_0300, 4'b0, "R7");
        cyc(1, 2, 32'h5000_0200, 1, 0, 32'h5000_0000, 4'b0, "R7");
        idle(5, "R7");                           // all stalled: bubbles
        cyc(0, 0, 0, 0, 0, 0, 4'b0100, "R7");
        idle(3, "R7");
        cyc(0, 0, 0, 0, 0, 0, 4'b1011, "R2");    // pointer order after bubbles
        idle(6, "R2");

        idle(2, "R3");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule